// File: doc/BRIEF.md
# Interrupt Pending and Arbitration Unit

This unit holds the interrupt-status field of a core's exception status word and decides when the core should take an interrupt. Each of the 13 interrupt lines reports its level through an indexed level-change port. The level is copied into that line's status bit. A local enable field selects which status bits may raise a request. A global enable input and a debug-mode input then decide whether the request may be acted on.

Three outputs come from the masked status. The first is a registered take-interrupt request for the exception entry logic. The second is the index of the highest-numbered masked pending line. The third is a wake indication that depends only on masked pending status. Bits 0 and 1 are software interrupts and can also be written directly. Bits 2 to 12 hold hardware line levels. Reset clears the local enable field and the two software bits. The hardware bits keep their values through reset and keep following line events while reset is held.

Top module: `irq_arbiter`

## Requirements
- R1: A level event with an index from 0 to 12 sets that status bit when the level is 1 and clears it when the level is 0. The change is visible on the outputs one clock after the event.
- R2: A level event with an index from 13 to 15 changes no status bit.
- R3: A software write replaces status bits 1:0 with `sw_bits_i[1:0]` and leaves bits 12:2 unchanged. When a level event hits bit 0 or 1 in the same cycle, the level event wins for that bit.
- R4: `wake_o` is 1 exactly when status AND local enable is nonzero. It does not depend on `gie_i` or `dbg_i`.
- R5: `vec_o` is the highest bit index set in status AND local enable, and it is 0 when that value is zero.
- R6: `take_o` is 1 one clock after a cycle in which `gie_i` is 1, `dbg_i` is 0 and a masked interrupt is pending. It is 0 one clock after a cycle in which any of those conditions does not hold.
- R7: `take_o` is 0 in the cycle after `ack_i` is 1, even when the take conditions still hold.
- R8: Reset clears the local enable field and status bits 1:0, and keeps status bits 12:2.
- R9: A local enable write replaces the whole 13-bit field with `lie_wdata_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lvl_valid_i | input | 1 | Line level event strobe |
| lvl_idx_i | input | 4 | Line index of the event |
| lvl_value_i | input | 1 | New level of the line |
| sw_we_i | input | 1 | Software status write strobe |
| sw_bits_i | input | 2 | New value of status bits 1:0 |
| lie_we_i | input | 1 | Local enable write strobe |
| lie_wdata_i | input | 13 | New local enable field |
| gie_i | input | 1 | Current-mode global interrupt enable |
| dbg_i | input | 1 | Core is in debug mode |
| ack_i | input | 1 | Entry logic accepts the request |
| take_o | output | 1 | Registered take-interrupt request |
| vec_o | output | 4 | Winning line index (0 when nothing pending) |
| wake_o | output | 1 | Masked interrupt pending, used for wake-up |

## Verification
The hardest state to reach is a reset taken while hardware status bits are set. The unit has no readback port, so what survives reset can only be seen after the local enable field is written again. The bench first sets a hardware bit and a software bit, then pulses reset. It checks that wake is low right after reset. It then restores the enable field and checks that the vector names the hardware bit and not the software bit. Arbitration is covered by every pair of lines and by cumulative fill and drain sweeps.

// File: rtl/irq_arb_pkg.sv
// Shared sizing constants for the interrupt arbitration unit.
// Assumes the software-interrupt bits occupy the lowest status positions.
package irq_arb_pkg;
    localparam int unsigned IRQ_LINES = 13;
    localparam int unsigned IRQ_SW    = 2;
    localparam int unsigned IRQ_IDX_W = 4;
endpackage

// File: rtl/irq_status_reg.sv
// Interrupt status field.
// Each bit copies the level of its line when an indexed level event names it.
// The lowest NSW bits are software interrupts: reset clears them and a software
// write may replace them. The other bits have no reset, so they hold their line
// levels through reset. Assumes at most one level event per cycle.
module irq_status_reg #(
    parameter int unsigned N   = 13,
    parameter int unsigned NSW = 2,
    parameter int unsigned IW  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           lvl_valid_i,
    input  logic [IW-1:0]  lvl_idx_i,
    input  logic           lvl_value_i,
    input  logic           sw_we_i,
    input  logic [NSW-1:0] sw_bits_i,
    output logic [N-1:0]   status_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic hit;
        assign hit = lvl_valid_i && (lvl_idx_i == IW'(i));
        if (i < NSW) begin : g_sw
            // Software bit: reset clears it; a level event wins over a software write.
            always_ff @(posedge clk) begin
                if (!rst_n)       status_o[i] <= 1'b0;
                else if (hit)     status_o[i] <= lvl_value_i;
                else if (sw_we_i) status_o[i] <= sw_bits_i[i];
            end
        end else begin : g_hw
            // Hardware bit: follows its line at all times, including during reset.
            always_ff @(posedge clk) begin
                if (hit) status_o[i] <= lvl_value_i;
            end
        end
    end

    // An out-of-range event with no software write leaves the field untouched.
    assert_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_valid_i && (32'(lvl_idx_i) >= N) && !sw_we_i) |=> $stable(status_o));

    // The software bits are zero after any reset cycle.
    assert_sw_reset_R8: assert property (@(posedge clk)
        !rst_n |=> (status_o[NSW-1:0] == '0));
endmodule

// File: rtl/irq_prio_enc.sv
// Priority encoder over the masked status. The highest set index wins.
// When no bit is set, the index is 0 and pending is low.
// Purely combinational; assumes N fits in IW bits.
module irq_prio_enc #(
    parameter int unsigned N  = 13,
    parameter int unsigned IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  masked_i,
    output logic          pending_o,
    output logic [IW-1:0] vec_o
);
    // Scan upward so that the last set bit seen, the highest, wins.
    always_comb begin
        vec_o = '0;
        for (int i = 0; i < N; i++) begin
            if (masked_i[i]) vec_o = IW'(i);
        end
    end

    // Pending whenever any masked bit is set.
    assign pending_o = |masked_i;

    // The winner is set and no higher bit is set.
    assert_winner_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pending_o |-> ((masked_i >> vec_o) == N'(1)));
endmodule

// File: rtl/irq_take_ctl.sv
// Registered take-interrupt request.
// The global enable counts only outside debug mode. An acknowledge forces the
// request low for the following cycle. Assumes the entry logic clears the
// global enable after it acknowledges, so the request does not come back.
module irq_take_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic gie_i,
    input  logic dbg_i,
    input  logic pending_i,
    input  logic ack_i,
    output logic take_o
);
    logic global_en;

    // Debug mode overrides the global enable.
    assign global_en = gie_i && !dbg_i;

    // Request register: clear on reset or acknowledge, else track enabled pending.
    always_ff @(posedge clk) begin
        if (!rst_n)     take_o <= 1'b0;
        else if (ack_i) take_o <= 1'b0;
        else            take_o <= global_en && pending_i;
    end

    assert_ack_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> !take_o);
    assert_dbg_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_i |=> !take_o);
    assert_gie_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !gie_i |=> !take_o);
endmodule

// File: rtl/irq_arbiter.sv
// Interrupt pending and arbitration top.
// Holds the status field and the local enable field. The masked status drives
// the wake indication and the winning vector combinationally, and drives the
// take request through one register. Exception entry and register saving are
// done elsewhere.
module irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int unsigned N   = IRQ_LINES,
    parameter int unsigned NSW = IRQ_SW,
    parameter int unsigned IW  = IRQ_IDX_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           lvl_valid_i,
    input  logic [IW-1:0]  lvl_idx_i,
    input  logic           lvl_value_i,
    input  logic           sw_we_i,
    input  logic [NSW-1:0] sw_bits_i,
    input  logic           lie_we_i,
    input  logic [N-1:0]   lie_wdata_i,
    input  logic           gie_i,
    input  logic           dbg_i,
    input  logic           ack_i,
    output logic           take_o,
    output logic [IW-1:0]  vec_o,
    output logic           wake_o
);
    logic [N-1:0] status;
    logic [N-1:0] lie_q;
    logic [N-1:0] masked;
    logic         pending;

    irq_status_reg #(.N(N), .NSW(NSW), .IW(IW)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .lvl_valid_i (lvl_valid_i),
        .lvl_idx_i   (lvl_idx_i),
        .lvl_value_i (lvl_value_i),
        .sw_we_i     (sw_we_i),
        .sw_bits_i   (sw_bits_i),
        .status_o    (status)
    );

    // Local enable field: cleared by reset, replaced whole by a write.
    always_ff @(posedge clk) begin
        if (!rst_n)        lie_q <= '0;
        else if (lie_we_i) lie_q <= lie_wdata_i;
    end

    // Only locally enabled status bits take part.
    assign masked = status & lie_q;

    irq_prio_enc #(.N(N), .IW(IW)) u_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .masked_i  (masked),
        .pending_o (pending),
        .vec_o     (vec_o)
    );

    irq_take_ctl u_take (
        .clk       (clk),
        .rst_n     (rst_n),
        .gie_i     (gie_i),
        .dbg_i     (dbg_i),
        .pending_i (pending),
        .ack_i     (ack_i),
        .take_o    (take_o)
    );

    // Wake ignores the global enable and debug mode.
    assign wake_o = pending;

    assert_idle_vec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_o |-> (vec_o == '0));
    assert_take_needs_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !$past(ack_i) && $past(wake_o)) |-> $past(gie_i));
endmodule

// File: tb/tb_irq_arbiter.sv
module tb_irq_arbiter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        lvl_valid_i, lvl_value_i, sw_we_i, lie_we_i, gie_i, dbg_i, ack_i;
    logic [3:0]  lvl_idx_i;
    logic [1:0]  sw_bits_i;
    logic [12:0] lie_wdata_i;
    logic        take_o, wake_o;
    logic [3:0]  vec_o;

    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    logic [12:0] m_stat = '0;
    logic [12:0] m_lie = '0;

    always #10 clk = ~clk;

    irq_arbiter dut (
        .clk(clk), .rst_n(rst_n), .lvl_valid_i(lvl_valid_i), .lvl_idx_i(lvl_idx_i),
        .lvl_value_i(lvl_value_i), .sw_we_i(sw_we_i), .sw_bits_i(sw_bits_i),
        .lie_we_i(lie_we_i), .lie_wdata_i(lie_wdata_i), .gie_i(gie_i), .dbg_i(dbg_i),
        .ack_i(ack_i), .take_o(take_o), .vec_o(vec_o), .wake_o(wake_o)
    );

    function automatic int exp_vec(logic [12:0] v);
        int r = 0;
        for (int i = 0; i < 13; i++) if (v[i]) r = i;
        return r;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic line(int idx, bit lvl);
        lvl_valid_i = 1'b1; lvl_idx_i = 4'(idx); lvl_value_i = lvl;
        step();
        lvl_valid_i = 1'b0;
        if (idx < 13) m_stat[idx] = lvl;
    endtask

    task automatic set_lie(logic [12:0] v);
        lie_we_i = 1'b1; lie_wdata_i = v;
        step();
        lie_we_i = 1'b0;
        m_lie = v;
    endtask

    task automatic chk_out(string req);
        chk({req, " vec"}, int'(vec_o), exp_vec(m_stat & m_lie));
        chk({req, " wake"}, int'(wake_o), int'(|(m_stat & m_lie)));
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0; lvl_valid_i = 0; lvl_idx_i = 0; lvl_value_i = 0; sw_we_i = 0;
        sw_bits_i = 0; lie_we_i = 0; lie_wdata_i = 0; gie_i = 0; dbg_i = 0; ack_i = 0;
        @(negedge clk);
        // Hardware bits are defined by line events sent during reset.
        for (int i = 2; i < 13; i++) line(i, 1'b0);
        rst_n = 1'b1;
        step();
        // R8 reset state
        chk("R8 reset take", int'(take_o), 0);
        chk("R8 reset wake", int'(wake_o), 0);
        chk("R8 reset vec", int'(vec_o), 0);

        set_lie(13'h1fff);
        chk_out("R9 lie all");
        // R1 R5 cumulative fill then drain
        for (int i = 0; i < 13; i++) begin line(i, 1'b1); chk_out("R1 fill"); end
        for (int i = 12; i >= 0; i--) begin line(i, 1'b0); chk_out("R1 drain"); end
        // R5 every pair: the higher index wins
        for (int a = 0; a < 13; a++) begin
            for (int b = a + 1; b < 13; b++) begin
                line(a, 1'b1); line(b, 1'b1);
                chk("R5 pair", int'(vec_o), b);
                line(a, 1'b0); line(b, 1'b0);
            end
        end
        // R9 R4 masking with all status set
        for (int i = 0; i < 13; i++) line(i, 1'b1);
        for (int k = 0; k < 13; k++) begin set_lie(13'(1 << k)); chk_out("R9 onehot"); end
        set_lie(13'h0055); chk_out("R9 pattern");
        set_lie(13'h0000); chk_out("R4 lie zero");
        set_lie(13'h1fff);
        for (int i = 0; i < 13; i++) line(i, 1'b0);
        // R2 out-of-range indices
        line(3, 1'b1);
        for (int j = 13; j < 16; j++) begin
            line(j, 1'b1); chk_out("R2 ignore set");
            line(j, 1'b0); chk_out("R2 ignore clear");
        end
        line(3, 1'b0);
        line(15, 1'b1); chk_out("R2 ignore idle");
        // R3 software write
        sw_we_i = 1; sw_bits_i = 2'b10; step(); sw_we_i = 0; m_stat[1:0] = 2'b10;
        chk_out("R3 sw 10");
        sw_we_i = 1; sw_bits_i = 2'b01; step(); sw_we_i = 0; m_stat[1:0] = 2'b01;
        chk_out("R3 sw 01");
        sw_we_i = 1; sw_bits_i = 2'b00; lvl_valid_i = 1; lvl_idx_i = 0; lvl_value_i = 1;
        step(); sw_we_i = 0; lvl_valid_i = 0; m_stat[1:0] = 2'b01;
        chk_out("R3 level wins");
        sw_we_i = 1; sw_bits_i = 2'b00; step(); sw_we_i = 0; m_stat[1:0] = 2'b00;
        chk_out("R3 sw clear");
        // R6 take gating
        line(7, 1'b1);
        step();
        chk("R6 gie off", int'(take_o), 0);
        chk("R4 wake without gie", int'(wake_o), 1);
        gie_i = 1; step();
        chk("R6 take", int'(take_o), 1);
        dbg_i = 1; step();
        chk("R6 debug blocks", int'(take_o), 0);
        chk("R4 wake in debug", int'(wake_o), 1);
        dbg_i = 0; step();
        chk("R6 debug released", int'(take_o), 1);
        // R7 acknowledge
        ack_i = 1; step(); ack_i = 0;
        chk("R7 ack drop", int'(take_o), 0);
        step();
        chk("R7 reassert", int'(take_o), 1);
        line(7, 1'b0); step();
        chk("R6 nothing pending", int'(take_o), 0);
        gie_i = 0;
        // R8 reset keeps hardware bits, clears software bits and enables
        line(5, 1'b1); line(1, 1'b1);
        chk("R8 before reset", int'(vec_o), 5);
        rst_n = 0; step(); step(); rst_n = 1; step();
        m_stat[1:0] = 2'b00; m_lie = '0;
        chk("R8 lie cleared", int'(wake_o), 0);
        set_lie(13'h0022);
        chk("R8 hw kept", int'(vec_o), 5);
        set_lie(13'h0002);
        chk("R8 sw cleared", int'(wake_o), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule